// File: doc/BRIEF.md
# Split-Phase Programmable Clock Divider

The block divides its input clock by an integer ratio that is never written as a single number. Software or a sequencer sets four values instead: a high-phase count, a low-phase count, a half-cycle flag and a bypass flag. These sit at fixed bit positions in one or two configuration words. The divided output is high for the high count of input cycles and low for the low count. When the half-cycle flag is set, the falling edge of the output moves half an input cycle later, so an odd ratio lands close to 50% duty. When the bypass flag is set, the input clock passes straight through. The block also reads back the ratio that is currently in effect.

A parameter selects one of two word layouts. The two-word layout suits output and feedback dividers. The single-word layout suits an input pre-divider. New words are taken in only at the rising edge that starts a new output period. A ratio change therefore never leaves a shortened pulse on the output.

Top module: `hilo_clk_divider`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is 0 and `ratio_o` reads 2 (active high count 1, low count 1, both flags clear). After release, the first rising edge of `clk_i` starts a new period with the words present at that edge.
- R2: With `PACK_SINGLE`=0, word 0 carries the high count in bits 11:6 and the low count in bits 5:0. Word 1 carries the half-cycle flag in bit 7 and the bypass flag in bit 6. All other bits of both words have no effect on `clk_o` or `ratio_o`.
- R3: With `PACK_SINGLE`=1, word 0 carries the half-cycle flag in bit 13, the bypass flag in bit 12, the high count in bits 11:6 and the low count in bits 5:0. Word 1 and word-0 bits above 13 have no effect.
- R4: A count field holding 0 stands for 64. Both fields at 0 give a ratio of 128.
- R5: With both flags clear, each period starts at a rising input edge. `clk_o` is high for the first H input cycles and low for the following L cycles, and every output transition sits on a rising input edge.
- R6: With the half-cycle flag set and bypass clear, `clk_o` stays high through the clock-high half of the first cycle after the high phase. It falls on that cycle's falling input edge, and the next period still rises on a rising edge.
- R7: With the bypass flag set, `clk_o` equals `clk_i`, and each period is one input cycle long.
- R8: `ratio_o` equals the active high count plus the active low count, or 1 while bypass is active. It changes only at period starts.
- R9: The words are sampled only at the rising edge that ends the last cycle of the current period. Changes made earlier in a period have no effect until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_word0_i | input | WORD_W | Configuration word 0 (count fields, plus flags in single-word layout) |
| cfg_word1_i | input | WORD_W | Configuration word 1 (flags in two-word layout, unused otherwise) |
| clk_o | output | 1 | Divided or bypassed clock |
| ratio_o | output | 8 | Ratio currently in effect |

## Verification
The assertions sample only at rising input edges. They assume the configuration words are stable around those edges, so the bench changes words 2 ns after a rising edge. The assertions tie the phase counter to the loaded configuration: loads happen only at period ends, the output rises only when the counter restarts, and it falls only when the count reaches the high value. The two half-period samples per input cycle cover what the rising-edge assertions cannot see: the half-cycle extension and the bypass path. Both layouts are driven from the same field values, with random filler in every bit that should have no effect.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned FIELD_W = 6;
  localparam int unsigned CNT_W   = FIELD_W + 1;
  localparam int unsigned RATIO_W = FIELD_W + 2;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic             half_f;
    logic             nocnt;
  } div_cfg_t;

  // A zero field encodes the largest count.
  function automatic logic [CNT_W-1:0] field_to_count(input logic [FIELD_W-1:0] f);
    return (f == '0) ? {1'b1, {FIELD_W{1'b0}}} : {1'b0, f};
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(input div_cfg_t c);
    if (c.nocnt) return RATIO_W'(1);
    return {1'b0, c.hi} + {1'b0, c.lo};
  endfunction
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter bit          PACK_SINGLE = 1'b0,
  parameter int unsigned WORD_W      = 16
) (
  input  logic [WORD_W-1:0] word0_i,
  input  logic [WORD_W-1:0] word1_i,
  output div_cfg_t          cfg_o
);
  localparam int unsigned LOW_LSB  = 0;
  localparam int unsigned HIGH_LSB = FIELD_W;
  localparam int unsigned CNT_TOP  = 2 * FIELD_W;

  logic unused_bits;

  assign cfg_o.lo = field_to_count(word0_i[LOW_LSB  +: FIELD_W]);
  assign cfg_o.hi = field_to_count(word0_i[HIGH_LSB +: FIELD_W]);

  generate
    if (PACK_SINGLE) begin : g_single
      localparam int unsigned NOC_BIT  = CNT_TOP;
      localparam int unsigned HALF_BIT = CNT_TOP + 1;
      assign cfg_o.nocnt  = word0_i[NOC_BIT];
      assign cfg_o.half_f = word0_i[HALF_BIT];
      assign unused_bits  = ^{word1_i, word0_i[WORD_W-1:HALF_BIT+1]};
    end else begin : g_pair
      localparam int unsigned NOC_BIT  = FIELD_W;
      localparam int unsigned HALF_BIT = FIELD_W + 1;
      assign cfg_o.nocnt  = word1_i[NOC_BIT];
      assign cfg_o.half_f = word1_i[HALF_BIT];
      assign unused_bits  = ^{word0_i[WORD_W-1:CNT_TOP],
                              word1_i[WORD_W-1:HALF_BIT+1],
                              word1_i[NOC_BIT-1:0]};
    end
  endgenerate
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
  import clkdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  div_cfg_t           cfg_next_i,
  output div_cfg_t           cfg_act_o,
  output logic               high_q_o,
  output logic               period_end_o,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam logic [RATIO_W-1:0] ONE_R   = RATIO_W'(1);
  localparam logic [CNT_W-1:0]   ONE_C   = CNT_W'(1);
  localparam div_cfg_t           RST_CFG = '{hi: ONE_C, lo: ONE_C, half_f: 1'b0, nocnt: 1'b0};

  logic [RATIO_W-1:0] pos_q, pos_nxt;
  div_cfg_t           cfg_q, cfg_nxt;
  logic               high_q, high_nxt;
  logic               period_end;

  assign ratio_o    = ratio_of(cfg_q);
  assign period_end = (pos_q == ratio_o - ONE_R);

  always_comb begin
    pos_nxt  = period_end ? '0 : pos_q + ONE_R;
    cfg_nxt  = period_end ? cfg_next_i : cfg_q;
    high_nxt = (pos_nxt < {1'b0, cfg_nxt.hi});
  end

  // Reset parks the counter on the last cycle of a ratio-2 period.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= ONE_R;
      cfg_q  <= RST_CFG;
      high_q <= 1'b0;
    end else begin
      pos_q  <= pos_nxt;
      cfg_q  <= cfg_nxt;
      high_q <= high_nxt;
    end
  end

  assign cfg_act_o    = cfg_q;
  assign high_q_o     = high_q;
  assign period_end_o = period_end;

  assert_pos_below_ratio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < ratio_o);
  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end |=> $stable(cfg_q));
  assert_rise_at_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(high_q) |-> (pos_q == '0));
  assert_fall_after_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(high_q) |-> (pos_q == {1'b0, cfg_q.hi}));
endmodule

// File: rtl/clkdiv_outmux.sv
module clkdiv_outmux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic high_q_i,
  input  logic half_en_i,
  input  logic bypass_i,
  output logic clk_o
);
  logic ext_q;
  logic div_clk;

  // Falling-edge copy stretches the high phase by half an input cycle.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= high_q_i;
  end

  assign div_clk = high_q_i | (half_en_i & ext_q);
  assign clk_o   = bypass_i ? clk_i : div_clk;
endmodule

// File: rtl/hilo_clk_divider.sv
module hilo_clk_divider
  import clkdiv_pkg::*;
#(
  parameter bit          PACK_SINGLE = 1'b0,
  parameter int unsigned WORD_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] cfg_word0_i,
  input  logic [WORD_W-1:0] cfg_word1_i,
  output logic              clk_o,
  output logic [7:0]        ratio_o
);
  div_cfg_t           cfg_next, cfg_act;
  logic               high_q, period_end;
  logic [RATIO_W-1:0] ratio;

  clkdiv_decode #(.PACK_SINGLE(PACK_SINGLE), .WORD_W(WORD_W)) u_decode (
    .word0_i (cfg_word0_i),
    .word1_i (cfg_word1_i),
    .cfg_o   (cfg_next)
  );

  clkdiv_phase u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_next_i   (cfg_next),
    .cfg_act_o    (cfg_act),
    .high_q_o     (high_q),
    .period_end_o (period_end),
    .ratio_o      (ratio)
  );

  clkdiv_outmux u_outmux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .high_q_i  (high_q),
    .half_en_i (cfg_act.half_f),
    .bypass_i  (cfg_act.nocnt),
    .clk_o     (clk_o)
  );

  assign ratio_o = 8'(ratio);

  assert_load_words_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> (cfg_act == $past(cfg_next)));
  assert_ratio_static_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end |=> $stable(ratio_o));
endmodule

// File: tb/sim_hilo_clk_divider.sv
`timescale 1ns/1ps
module sim_hilo_clk_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
  logic        clk0, clk1;
  logic [7:0]  r0, r1;

  int n_chk = 0, n_err = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  int f_hi = 4, f_lo = 4, f_half = 0, f_noc = 0;
  int m_pos = 1, m_hi = 1, m_lo = 1, m_half = 0, m_noc = 0;

  always #2.5 clk_i = ~clk_i;

  hilo_clk_divider #(.PACK_SINGLE(1'b0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_word0_i(a0), .cfg_word1_i(a1),
    .clk_o(clk0), .ratio_o(r0));
  hilo_clk_divider #(.PACK_SINGLE(1'b1)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_word0_i(b0), .cfg_word1_i(b1),
    .clk_o(clk1), .ratio_o(r1));

  function automatic int eff(int f);
    return (f == 0) ? 64 : f;
  endfunction

  function automatic int m_ratio();
    return (m_noc != 0) ? 1 : m_hi + m_lo;
  endfunction

  // Reference model: period position and active fields, one step per rising edge.
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pos = 1; m_hi = 1; m_lo = 1; m_half = 0; m_noc = 0;
    end else if (m_pos == m_ratio() - 1) begin
      m_pos = 0; m_hi = eff(f_hi); m_lo = eff(f_lo); m_half = f_half; m_noc = f_noc;
    end else begin
      m_pos = m_pos + 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sample(bit first_half);
    int    exp_clk;
    string t;
    if (m_noc != 0) begin
      exp_clk = first_half ? 1 : 0; t = "R7";
    end else if (first_half && m_half != 0 && m_pos == m_hi) begin
      exp_clk = 1; t = "R6";
    end else begin
      exp_clk = (m_pos < m_hi) ? 1 : 0; t = "R5";
    end
    if (!rst_ni) t = "R1";
    check({"u0/R2 clk ", t}, int'(clk0), exp_clk);
    check({"u1/R3 clk ", t}, int'(clk1), exp_clk);
    check(rst_ni ? "u0/R8 ratio" : "u0/R1 ratio", int'(r0), m_ratio());
    check(rst_ni ? "u1/R8 ratio" : "u1/R1 ratio", int'(r1), m_ratio());
  endtask

  initial begin
    forever begin
      @(posedge clk_i); #1.25;
      if (chk_on) sample(1'b1);
      @(negedge clk_i); #1.25;
      if (chk_on) sample(1'b0);
    end
  end

  int seq = 0;
  task automatic set_cfg(int hi, int lo, int half, int noc);
    logic [15:0] junk;
    seq++;
    junk = 16'hA5C3 ^ 16'(seq * 16'h3B71);
    f_hi = hi; f_lo = lo; f_half = half; f_noc = noc;
    a0 = {junk[15:12], 6'(hi), 6'(lo)};
    a1 = {junk[11:4], 1'(half), 1'(noc), junk[5:0]};
    b0 = {junk[1:0], 1'(half), 1'(noc), 6'(hi), 6'(lo)};
    b1 = ~junk;
  endtask

  task automatic run(int hi, int lo, int half, int noc, int cycles);
    @(posedge clk_i); #2;
    set_cfg(hi, lo, half, noc);
    repeat (cycles) @(posedge clk_i);
  endtask

  task automatic finish_run();
    chk_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(50000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    set_cfg(4, 4, 0, 0);
    #1; chk_on = 1'b1;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;                    // R1: first period starts at next rising edge
    repeat (40) @(posedge clk_i);        // R5 even ratio 8
    run(1, 1, 0, 0, 12);                 // R5 ratio 2
    run(3, 4, 1, 0, 40);                 // R6 ratio 7 with half-cycle stretch
    run(1, 2, 1, 0, 20);                 // R6 ratio 3
    run(0, 1, 1, 1, 10);                 // R7 bypass, zero high field irrelevant
    run(2, 3, 1, 0, 30);                 // leaving bypass
    run(0, 0, 0, 0, 300);                // R4 both fields zero
    #1.25 check("u0/R4 ratio 128", int'(r0), 128);
    check("u1/R4 ratio 128", int'(r1), 128);
    run(63, 0, 1, 0, 300);               // R4 low field zero, odd ratio 127
    run(0, 1, 1, 1, 6);                  // R7 bypass again
    run(4, 4, 0, 0, 20);
    // R9: mid-period change waits for the period boundary
    do begin @(posedge clk_i); #0.5; end while (m_pos != 1);
    #1.5 set_cfg(2, 2, 0, 0);
    @(posedge clk_i); #1.25;
    check("u0/R9 ratio held", int'(r0), 8);
    check("u1/R9 ratio held", int'(r1), 8);
    repeat (10) @(posedge clk_i); #1.25;
    check("u0/R9 ratio loaded", int'(r0), 4);
    check("u1/R9 ratio loaded", int'(r1), 4);
    run(5, 6, 0, 0, 40);
    done = 1'b1;
    finish_run();
  end
endmodule